// File: doc/BRIEF.md
# Counted Pulse Burst Generator

This block drives one output pin with a train of pulses whose count, period and low time are set by software. Three write ports load its settings: a one-bit mode setting selects the output polarity, a 32-bit timing word holds the period and the low time, both counted in system clocks, and a count word starts a burst. When software writes a nonzero count, the block emits exactly that many complete pulses. It then raises a done flag, which software polls before it loads the next count.

Each pulse starts with its low phase, which lasts the programmed low time. The output is then high for the rest of the period. With the invert setting, the pin idles at logic 1 and the pulses are logic-0 pulses. The pin is driven only while the enable input is high. Dropping enable returns the block to an off state.

The control is a four-state machine. ST_OFF is entered while enable is low. ST_IDLE waits for a count. ST_LOW is the low phase of a pulse and ST_HIGH is the high phase. The named transitions are:
- ENABLE: ST_OFF to ST_IDLE.
- START: ST_IDLE to the first phase, on a nonzero count write.
- SWITCH: ST_LOW to ST_HIGH, when the low time has run out.
- NEXT: the end of a pulse back to its first phase, when more pulses are due.
- FINISH: the end of a pulse to ST_IDLE.
- DISABLE: any state to ST_OFF.

Top module: `pulse_burst_gen`

## Requirements
- R1: After reset, done_flag is 0 and pin_out is at the idle level (0 with invert off). pin_oe follows enable in every cycle.
- R2: Timing word bits [15:0] hold the period P and bits [31:16] hold the low time L. Each pulse lasts P cycles: first L cycles at the inactive level, then P-L cycles at the active level. Pulses follow each other with no gap.
- R3: A count write of N>0 made in ST_IDLE gives exactly N pulses. The first pulse cycle is the one after the write edge. A count of 0 gives no pulse, and the flag stays 0 afterwards.
- R4: A count write clears done_flag at the edge that samples it. done_flag rises at the edge that ends the last pulse, which is N*P edges after the write edge, and stays high until the next count write or until enable drops.
- R5: After a burst completes, a new count write starts a fresh burst with the same timing.
- R6: With mode_invert=1 (set by a mode_wr write), the idle level is 1, the inactive phase drives 1 and the active phase drives 0. With mode_invert=0 the levels are the reverse.
- R7: If L>=P, the whole pulse stays at the inactive level, and the pulse still counts toward N. If L=0, the whole pulse is at the active level.
- R8: A count write during a burst takes effect at the next pulse boundary. The pulse in progress completes. If the new count is nonzero, that many new pulses follow, and the flag rises only when they end. If the new count is 0, the burst stops at the boundary and the flag stays 0.
- R9: While enable is low: pin_oe is 0, pin_out is at the idle level, done_flag is 0, the counters are cleared, and count writes are ignored. After enable returns, the block idles until a new count write.
- R10: A programmed period of 0 acts as a period of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Pin direction/enable; the generator runs only while high |
| mode_wr | input | 1 | Write strobe for mode_invert |
| mode_invert | input | 1 | Output polarity: 1 inverts the pin |
| timing_wr | input | 1 | Write strobe for timing_data |
| timing_data | input | 2*TW | Period in [TW-1:0], low time in [2*TW-1:TW] |
| count_wr | input | 1 | Write strobe for count_data |
| count_data | input | CW | Number of pulses in the burst |
| pin_out | output | 1 | Pulse output level |
| pin_oe | output | 1 | Output enable for the pin |
| done_flag | output | 1 | Burst-complete flag |

## Verification
The bound checker checks these properties on every cycle:
- A count write clears the flag at the next edge.
- The flag rises only when the block leaves a pulse phase for ST_IDLE.
- Dropping enable forces ST_OFF and a low flag.
- A zero count written in ST_IDLE starts nothing.
- A burst with a nonzero low time opens in ST_LOW.

Some behaviour only the directed scenarios can show: the exact waveform (low-first split, period clamp, L>=P and L=0), the exact pulse count, the flag timing N*P edges after the write, the boundary handover of a mid-burst rewrite, polarity inversion, and the ignored writes while disabled.

// File: rtl/pbg_pkg.sv
package pbg_pkg;

    // Control states of the burst generator
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,   // enable low, nothing driven
        ST_IDLE = 2'd1,   // enabled, waiting for a count
        ST_LOW  = 2'd2,   // inactive phase of a pulse
        ST_HIGH = 2'd3    // active phase of a pulse
    } pbg_state_e;

endpackage

// File: rtl/pbg_cfg.sv
module pbg_cfg #(
    parameter int TW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mode_wr,
    input  logic            mode_invert,
    input  logic            timing_wr,
    input  logic [2*TW-1:0] timing_data,
    output logic            inv_q,
    output logic [TW-1:0]   period_eff,
    output logic [TW-1:0]   low_q,
    output logic            low_zero
);

    logic [TW-1:0] period_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            inv_q <= 1'b0;
        end else if (mode_wr) begin
            inv_q <= mode_invert;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            period_q <= '0;
            low_q    <= '0;
        end else if (timing_wr) begin
            period_q <= timing_data[TW-1:0];
            low_q    <= timing_data[2*TW-1:TW];
        end
    end

    // A zero period is treated as a single-cycle period (R10)
    always_comb begin
        period_eff = (period_q == '0) ? TW'(1) : period_q;
        low_zero   = (low_q == '0);
    end

endmodule

// File: rtl/pbg_timer.sv
module pbg_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          restart,
    input  logic          run,
    input  logic [TW-1:0] period_eff,
    input  logic [TW-1:0] low_len,
    output logic          at_end,
    output logic          low_done
);

    logic [TW-1:0] tick_q;
    logic [TW:0]   tick_inc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_q <= '0;
        end else if (!enable || restart) begin
            tick_q <= '0;
        end else if (run) begin
            tick_q <= tick_q + TW'(1);
        end
    end

    always_comb begin
        tick_inc = {1'b0, tick_q} + (TW+1)'(1);
        at_end   = (tick_q == period_eff - TW'(1));
        low_done = (tick_inc >= {1'b0, low_len});
    end

endmodule

// File: rtl/pbg_count.sv
module pbg_count #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          cnt_wr,
    input  logic [CW-1:0] cnt_data,
    input  logic          busy,
    input  logic          pulse_end,
    output logic          more,
    output logic          natural_end
);

    logic [CW-1:0] remain_q;
    logic [CW-1:0] pend_val_q;
    logic          pend_v_q;
    logic          wr_busy;
    logic          eff_pend;
    logic [CW-1:0] eff_val;

    always_comb begin
        wr_busy     = cnt_wr && busy;
        eff_pend    = pend_v_q || wr_busy;
        eff_val     = wr_busy ? cnt_data : pend_val_q;
        more        = eff_pend ? (eff_val != '0) : (remain_q > CW'(1));
        natural_end = !eff_pend;
    end

    // Pulses left in the burst, including the one in progress
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (!enable) begin
            remain_q <= '0;
        end else if (cnt_wr && !busy) begin
            remain_q <= cnt_data;
        end else if (pulse_end) begin
            remain_q <= eff_pend ? eff_val : remain_q - CW'(1);
        end
    end

    // A count written mid-burst waits for the next pulse boundary
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_v_q   <= 1'b0;
            pend_val_q <= '0;
        end else if (!enable || pulse_end) begin
            pend_v_q   <= 1'b0;
        end else if (wr_busy) begin
            pend_v_q   <= 1'b1;
            pend_val_q <= cnt_data;
        end
    end

endmodule

// File: rtl/pbg_fsm.sv
module pbg_fsm
    import pbg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       cnt_wr,
    input  logic       cnt_nonzero,
    input  logic       at_end,
    input  logic       low_done,
    input  logic       low_zero,
    input  logic       more,
    input  logic       natural_end,
    output pbg_state_e state_q,
    output logic       busy,
    output logic       pulse_end,
    output logic       restart,
    output logic       flag_q
);

    pbg_state_e state_d;
    pbg_state_e first_ph;
    logic       start;

    always_comb begin
        first_ph  = low_zero ? ST_HIGH : ST_LOW;
        busy      = (state_q == ST_LOW) || (state_q == ST_HIGH);
        pulse_end = busy && at_end;
        start     = (state_q == ST_IDLE) && cnt_wr && cnt_nonzero;
        restart   = start || pulse_end;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (enable) state_d = ST_IDLE;                   // ENABLE
            end
            ST_IDLE: begin
                if (start) state_d = first_ph;                   // START
            end
            ST_LOW: begin
                if (at_end)        state_d = more ? first_ph : ST_IDLE; // NEXT / FINISH
                else if (low_done) state_d = ST_HIGH;                   // SWITCH
            end
            ST_HIGH: begin
                if (at_end) state_d = more ? first_ph : ST_IDLE;        // NEXT / FINISH
            end
            default: state_d = ST_OFF;
        endcase
        if (!enable) state_d = ST_OFF;                           // DISABLE
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (!enable || cnt_wr) begin
            flag_q <= 1'b0;
        end else if (pulse_end && !more && natural_end) begin
            flag_q <= 1'b1;
        end
    end

endmodule

// File: rtl/pulse_burst_gen.sv
module pulse_burst_gen
    import pbg_pkg::*;
#(
    parameter int TW = 16,
    parameter int CW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic            mode_wr,
    input  logic            mode_invert,
    input  logic            timing_wr,
    input  logic [2*TW-1:0] timing_data,
    input  logic            count_wr,
    input  logic [CW-1:0]   count_data,
    output logic            pin_out,
    output logic            pin_oe,
    output logic            done_flag
);

    logic          inv_q;
    logic [TW-1:0] period_eff;
    logic [TW-1:0] low_q;
    logic          low_zero;
    logic          at_end;
    logic          low_done;
    logic          more;
    logic          natural_end;
    logic          busy;
    logic          pulse_end;
    logic          restart;
    logic          cnt_acc;
    pbg_state_e    state_q;

    // Count writes count only once the block has left ST_OFF
    always_comb cnt_acc = count_wr && enable && (state_q != ST_OFF);

    pbg_cfg #(.TW(TW)) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_wr     (mode_wr),
        .mode_invert (mode_invert),
        .timing_wr   (timing_wr),
        .timing_data (timing_data),
        .inv_q       (inv_q),
        .period_eff  (period_eff),
        .low_q       (low_q),
        .low_zero    (low_zero)
    );

    pbg_timer #(.TW(TW)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .restart    (restart),
        .run        (busy),
        .period_eff (period_eff),
        .low_len    (low_q),
        .at_end     (at_end),
        .low_done   (low_done)
    );

    pbg_count #(.CW(CW)) u_count (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .cnt_wr      (cnt_acc),
        .cnt_data    (count_data),
        .busy        (busy),
        .pulse_end   (pulse_end),
        .more        (more),
        .natural_end (natural_end)
    );

    pbg_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .cnt_wr      (cnt_acc),
        .cnt_nonzero (count_data != '0),
        .at_end      (at_end),
        .low_done    (low_done),
        .low_zero    (low_zero),
        .more        (more),
        .natural_end (natural_end),
        .state_q     (state_q),
        .busy        (busy),
        .pulse_end   (pulse_end),
        .restart     (restart),
        .flag_q      (done_flag)
    );

    // Output process: active level only in ST_HIGH, polarity from mode
    always_comb begin
        pin_oe  = enable;
        pin_out = inv_q ^ (state_q == ST_HIGH);
    end

endmodule

// File: rtl/pbg_checker.sv
module pbg_checker
    import pbg_pkg::*;
#(
    parameter int TW = 16,
    parameter int CW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          enable,
    input logic          count_wr,
    input logic [CW-1:0] count_data,
    input logic          done_flag,
    input logic [TW-1:0] low_q,
    input pbg_state_e    state_q
);

    // R4: an accepted count write clears the flag at the next edge
    a_r4_flag_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && count_wr && state_q != ST_OFF) |=> !done_flag);

    // R4: the flag only rises when a pulse phase hands over to ST_IDLE
    a_r4_flag_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> (state_q == ST_IDLE &&
            ($past(state_q) == ST_LOW || $past(state_q) == ST_HIGH)));

    // R9: disabling forces ST_OFF with the flag low
    a_r9_disable_off: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (state_q == ST_OFF && !done_flag));

    // R3: a zero count written while idle starts nothing
    a_r3_zero_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && state_q == ST_IDLE && count_wr && count_data == '0)
            |=> (state_q == ST_IDLE || state_q == ST_OFF));

    // R2: a burst with a nonzero low time opens in the low phase
    a_r2_low_first: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && state_q == ST_IDLE && count_wr && count_data != '0 && low_q != '0)
            |=> (state_q == ST_LOW || state_q == ST_OFF));

endmodule

bind pulse_burst_gen pbg_checker #(.TW(TW), .CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .count_wr   (count_wr),
    .count_data (count_data),
    .done_flag  (done_flag),
    .low_q      (low_q),
    .state_q    (state_q)
);

// File: tb/pulse_burst_gen_test.sv
module pulse_burst_gen_test;

    localparam int CLK_PERIOD = 10;
    localparam int TW = 16;
    localparam int CW = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            enable = 1'b0;
    logic            mode_wr = 1'b0;
    logic            mode_invert = 1'b0;
    logic            timing_wr = 1'b0;
    logic [2*TW-1:0] timing_data = '0;
    logic            count_wr = 1'b0;
    logic [CW-1:0]   count_data = '0;
    logic            pin_out;
    logic            pin_oe;
    logic            done_flag;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pulse_burst_gen #(.TW(TW), .CW(CW)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .mode_wr     (mode_wr),
        .mode_invert (mode_invert),
        .timing_wr   (timing_wr),
        .timing_data (timing_data),
        .count_wr    (count_wr),
        .count_data  (count_data),
        .pin_out     (pin_out),
        .pin_oe      (pin_oe),
        .done_flag   (done_flag)
    );

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic set_cfg(bit inv, int per, int low);
        @(negedge clk);
        mode_wr     = 1'b1;
        mode_invert = inv;
        timing_wr   = 1'b1;
        timing_data = {low[15:0], per[15:0]};
        @(negedge clk);
        mode_wr   = 1'b0;
        timing_wr = 1'b0;
    endtask

    // Writes n1, optionally rewrites n2 after sample mid_s, and compares
    // pin_out/done_flag against the expected waveform sample by sample.
    task automatic run_burst(string req, bit inv, int per, int low,
                             int n1, int mid_s, int n2);
        int pe, seg1_end, seg2_start, seg2_end, flag_at, total;
        int bad_out, bad_flag, first_out_s, act_o, exp_o, act_f, exp_f;
        set_cfg(inv, per, low);
        pe = (per == 0) ? 1 : per;
        if (mid_s >= 0) begin
            seg2_start = ((mid_s + 1 + pe - 1) / pe) * pe;
            seg1_end   = seg2_start;
            seg2_end   = seg2_start + n2 * pe;
            flag_at    = (n2 > 0) ? seg2_end : -1;
            total      = seg2_end;
        end else begin
            seg1_end   = n1 * pe;
            seg2_start = 0;
            seg2_end   = 0;
            flag_at    = (n1 > 0) ? seg1_end : -1;
            total      = seg1_end;
        end
        @(negedge clk);
        count_wr   = 1'b1;
        count_data = n1;
        @(negedge clk);
        count_wr = 1'b0;
        bad_out = 0; bad_flag = 0; first_out_s = -1;
        act_o = 0; exp_o = 0; act_f = 0; exp_f = 0;
        for (int s = 0; s <= total + 3; s++) begin
            bit hi;
            bit eo;
            bit ef;
            count_wr = 1'b0;
            hi = 1'b0;
            if (s < seg1_end && ((s % pe) >= low)) hi = 1'b1;
            if (mid_s >= 0 && s >= seg2_start && s < seg2_end &&
                (((s - seg2_start) % pe) >= low)) hi = 1'b1;
            eo = inv ^ hi;
            ef = (flag_at >= 0) && (s >= flag_at);
            if (pin_out !== eo) begin
                if (bad_out == 0) begin
                    first_out_s = s; act_o = pin_out; exp_o = eo;
                end
                bad_out++;
            end
            if (done_flag !== ef) begin
                if (bad_flag == 0) begin
                    act_f = done_flag; exp_f = ef;
                end
                bad_flag++;
            end
            if (s == mid_s) begin
                count_wr   = 1'b1;
                count_data = n2;
            end
            @(negedge clk);
        end
        count_wr = 1'b0;
        check(bad_out == 0, req, $sformatf("pin_out first mismatch at sample %0d", first_out_s),
              act_o, exp_o);
        check(bad_flag == 0, {req, " R4"}, "done_flag first mismatch", act_f, exp_f);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; enable = 1'b0;
        repeat (3) @(negedge clk);
        check(done_flag == 1'b0, "R1", "flag in reset", done_flag, 0);
        check(pin_out == 1'b0, "R1", "pin_out in reset", pin_out, 0);
        check(pin_oe == 1'b0, "R1", "pin_oe with enable low", pin_oe, 0);
        rst_n = 1'b1;
        @(negedge clk);
        enable = 1'b1;
        repeat (2) @(negedge clk);
        check(pin_oe == 1'b1, "R1", "pin_oe with enable high", pin_oe, 1);
        check(pin_out == 1'b0 && done_flag == 1'b0, "R1", "idle after enable",
              {pin_out, done_flag}, 0);
    endtask

    task automatic t_disable();
        set_cfg(1'b0, 4, 2);
        @(negedge clk); count_wr = 1'b1; count_data = 5;
        @(negedge clk); count_wr = 1'b0;
        repeat (5) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        check(pin_oe == 1'b0, "R9", "pin_oe after disable", pin_oe, 0);
        check(pin_out == 1'b0 && done_flag == 1'b0, "R9", "idle level and flag after disable",
              {pin_out, done_flag}, 0);
        count_wr = 1'b1; count_data = 3;
        @(negedge clk); count_wr = 1'b0;
        repeat (3) @(negedge clk);
        enable = 1'b1;
        begin
            int seen = 0;
            for (int k = 0; k < 20; k++) begin
                @(negedge clk);
                if (pin_out !== 1'b0 || done_flag !== 1'b0) seen++;
            end
            check(seen == 0, "R9", "activity from write made while disabled", seen, 0);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        run_burst("R2 R3", 1'b0, 6, 2, 3, -1, 0);
        run_burst("R5", 1'b0, 5, 1, 2, -1, 0);
        run_burst("R3 zero count", 1'b0, 5, 1, 0, -1, 0);
        run_burst("R6", 1'b1, 4, 1, 2, -1, 0);
        run_burst("R6 back to normal", 1'b0, 3, 1, 1, -1, 0);
        run_burst("R7 low>=period", 1'b0, 5, 7, 2, -1, 0);
        run_burst("R7 low zero", 1'b0, 3, 0, 2, -1, 0);
        run_burst("R10", 1'b0, 0, 0, 3, -1, 0);
        run_burst("R8 rewrite", 1'b0, 4, 1, 5, 5, 2);
        run_burst("R8 rewrite on boundary", 1'b0, 4, 1, 5, 6, 1);
        run_burst("R8 zero rewrite", 1'b0, 3, 1, 4, 2, 0);
        t_disable();
        run_burst("R9 after re-enable", 1'b0, 4, 2, 1, -1, 0);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule